// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain, single-wire data lines: one on the host side and one on the card side. Both lines rest high on passive pull-ups. The first side seen to fall becomes the master for that transfer. After a fixed delay, the block copies the master's low level onto the other side, the slave, by pulling the slave low. While the transfer lasts, falling edges on the slave side are ignored.

When the master lets its line rise again, the block stops pulling the slave low. It then drives the slave actively high for a short, fixed pulse so the line rises quickly. After that both sides return to passive idle. Each line enters through a synchronizer, and every delay is counted in system clock cycles.

A session controller gates the block through a single enable. While the enable is low, the card line is held low and the host line is left passive. There is no data stream at this edge: the two line levels and the four drive outputs are plain level signals with no valid/ready handshake and no back-pressure. Pull-up resistors, current limiting and level shifting belong to the pads, not to this block.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, with both lines high and the enable high, all four drive outputs (`host_pull_lo`, `host_drive_hi`, `card_pull_lo`, `card_drive_hi`) are 0.
- R2: When the host line falls first, `card_pull_lo` rises exactly SYNC_STAGES+1+FALL_DLY clock edges after the change on `host_in`. Before that it stays 0, and `host_pull_lo` stays 0 throughout.
- R3: When the card line falls first, `host_pull_lo` rises exactly SYNC_STAGES+1+FALL_DLY clock edges after the change on `card_in`, and `card_pull_lo` stays 0.
- R4: SYNC_STAGES+1 clock edges after the master's line returns high, the slave's pull-low is released. On that same edge, the slave's drive-high output rises and stays high for exactly PULSE_LEN cycles, then returns to 0.
- R5: A falling edge on the slave side during a transfer never pulls the master side low.
- R6: If both lines fall in the same sampled cycle, the host side becomes master: the card side is pulled low and the host side is not.
- R7: A master low period of FALL_DLY cycles or fewer is not forwarded. The slave is neither pulled low nor driven high.
- R8: While `enable` is 0, `card_pull_lo` is 1 and `host_pull_lo` and `host_drive_hi` are 0, in the same cycle. Any transfer in progress is dropped, so no drive-high pulse follows when the enable returns.
- R9: A falling edge on the master line that arrives while its drive-high pulse is still running is ignored. No new transfer starts after the pulse ends.
- R10: No side is pulled low and driven high at once, and the two sides are never pulled low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Session enable; 0 parks the card line low |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_pull_lo | output | 1 | Pull the host line low |
| host_drive_hi | output | 1 | Actively drive the host line high |
| card_pull_lo | output | 1 | Pull the card line low |
| card_drive_hi | output | 1 | Actively drive the card line high |

## Verification
The bench models each line as a wired-AND of an external driver and the block's own pull-low, so the block sees its own drive fed back into its inputs. It checks that the propagation delay is exact to the edge in both directions, since a block off by one in its synchronizer or timer would shift the pull by a cycle. It drives a too-short low pulse, which a design missing the abort path would stretch onto the slave, and a simultaneous fall, which a design that mixed up priority would forward toward the host. It also drops a slave edge in mid-transfer, a master edge in mid-pulse and the enable in mid-hold; a design without the lockout, the pulse guard or the enable override would pull the wrong side, start a phantom transfer or leave a pulse dangling.

// File: rtl/od_rep_pkg.sv
package od_rep_pkg;

  typedef enum logic [1:0] {
    RP_IDLE  = 2'd0,
    RP_WAIT  = 2'd1,
    RP_HOLD  = 2'd2,
    RP_PULSE = 2'd3
  } rep_state_e;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } rep_side_e;

endpackage

// File: rtl/od_line_sync.sv
module od_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  // Lines idle high, so the chain resets to 1 to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign fall = prev & ~lvl;
endmodule

// File: rtl/od_rep_timer.sv
module od_rep_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/od_rep_ctrl.sv
module od_rep_ctrl
  import od_rep_pkg::*;
#(
  parameter int FALL_DLY  = 50,
  parameter int PULSE_LEN = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic host_lvl,
  input  logic host_fall,
  input  logic card_lvl,
  input  logic card_fall,
  output logic host_pull,
  output logic host_drv,
  output logic card_pull,
  output logic card_drv
);
  localparam int MAXV = (FALL_DLY > PULSE_LEN) ? FALL_DLY : PULSE_LEN;
  localparam int CW   = $clog2(MAXV + 1);

  rep_state_e state, state_nx;
  rep_side_e  master, master_nx;
  logic       tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic       master_lvl;

  assign master_lvl = (master == SIDE_HOST) ? host_lvl : card_lvl;

  always_comb begin
    state_nx  = state;
    master_nx = master;
    tmr_load  = 1'b0;
    tmr_val   = CW'(FALL_DLY - 1);
    if (!enable) begin
      state_nx = RP_IDLE;
    end else begin
      unique case (state)
        RP_IDLE: begin
          // host wins a tie
          if (host_fall) begin
            state_nx  = RP_WAIT;
            master_nx = SIDE_HOST;
            tmr_load  = 1'b1;
          end else if (card_fall) begin
            state_nx  = RP_WAIT;
            master_nx = SIDE_CARD;
            tmr_load  = 1'b1;
          end
        end
        RP_WAIT: begin
          if (master_lvl)    state_nx = RP_IDLE;
          else if (tmr_zero) state_nx = RP_HOLD;
        end
        RP_HOLD: begin
          if (master_lvl) begin
            state_nx = RP_PULSE;
            tmr_load = 1'b1;
            tmr_val  = CW'(PULSE_LEN - 1);
          end
        end
        RP_PULSE: begin
          if (tmr_zero) state_nx = RP_IDLE;
        end
        default: state_nx = RP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RP_IDLE;
      master <= SIDE_HOST;
    end else begin
      state  <= state_nx;
      master <= master_nx;
    end
  end

  od_rep_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // The slave is the side opposite the master.
  assign card_pull = (state == RP_HOLD)  && (master == SIDE_HOST);
  assign card_drv  = (state == RP_PULSE) && (master == SIDE_HOST);
  assign host_pull = (state == RP_HOLD)  && (master == SIDE_CARD);
  assign host_drv  = (state == RP_PULSE) && (master == SIDE_CARD);

  assert_one_side_pull_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull && card_pull));

  assert_no_fight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull && host_drv) && !(card_pull && card_drv));

  assert_pulse_follows_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_drv) |-> $past(card_pull));

  assert_card_pull_needs_low_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pull) |-> !$past(host_lvl));

  assert_host_pull_needs_low_card_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_pull) |-> !$past(card_lvl));
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater #(
  parameter int SYNC_STAGES = 2,
  parameter int FALL_DLY    = 50,
  parameter int PULSE_LEN   = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull_lo,
  output logic host_drive_hi,
  output logic card_pull_lo,
  output logic card_drive_hi
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0] raw, lvl, fall;
  logic c_host_pull, c_host_drv, c_card_pull, c_card_drv;

  assign raw = {card_in, host_in};

  for (genvar g = 0; g < NSIDE; g++) begin : g_sync
    od_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .lvl  (lvl[g]),
      .fall (fall[g])
    );
  end

  od_rep_ctrl #(.FALL_DLY(FALL_DLY), .PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .host_lvl (lvl[0]),
    .host_fall(fall[0]),
    .card_lvl (lvl[1]),
    .card_fall(fall[1]),
    .host_pull(c_host_pull),
    .host_drv (c_host_drv),
    .card_pull(c_card_pull),
    .card_drv (c_card_drv)
  );

  assign card_pull_lo  = ~enable | c_card_pull;
  assign card_drive_hi = enable & c_card_drv;
  assign host_pull_lo  = enable & c_host_pull;
  assign host_drive_hi = enable & c_host_drv;

  assert_disable_drops_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(c_host_pull || c_host_drv || c_card_pull || c_card_drv));
endmodule

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb;
  localparam int SYNC  = 2;
  localparam int FALL  = 50;
  localparam int PULSE = 25;
  localparam int LAT_F = SYNC + 1 + FALL;
  localparam int LAT_R = SYNC + 1;
  localparam int NVEC  = 5;

  // {side(0=host,1=card), low length in cycles, expect forwarded}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 16'd80,  1'b1},
    {1'b1, 16'd120, 1'b1},
    {1'b0, 16'd20,  1'b0},
    {1'b1, 16'd60,  1'b1},
    {1'b1, 16'd30,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic host_ext = 1'b1, card_ext = 1'b1;
  logic host_in, card_in;
  logic host_pull_lo, host_drive_hi, card_pull_lo, card_drive_hi;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign host_in = host_ext & ~host_pull_lo;
  assign card_in = card_ext & ~card_pull_lo;

  od_line_repeater #(.SYNC_STAGES(SYNC), .FALL_DLY(FALL), .PULSE_LEN(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .host_in(host_in), .card_in(card_in),
    .host_pull_lo(host_pull_lo), .host_drive_hi(host_drive_hi),
    .card_pull_lo(card_pull_lo), .card_drive_hi(card_drive_hi)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {host_pull_lo, host_drive_hi, card_pull_lo, card_drive_hi};
  endfunction

  task automatic set_side(input logic side, input logic v);
    if (side) card_ext = v; else host_ext = v;
  endtask

  // slave drive bits {pull, drive} picked from outs for the given master
  function automatic logic [1:0] slave_of(input logic side);
    return side ? {host_pull_lo, host_drive_hi} : {card_pull_lo, card_drive_hi};
  endfunction
  function automatic logic [1:0] master_of(input logic side);
    return side ? {card_pull_lo, card_drive_hi} : {host_pull_lo, host_drive_hi};
  endfunction

  task automatic xfer(input logic side, input int len, input logic fwd);
    logic bad;
    set_side(side, 1'b0);
    if (fwd) begin
      step(LAT_F - 1);
      check(side ? "R3 before delay" : "R2 before delay", {2'b0, slave_of(side)}, 4'b0000);
      step(1);
      check(side ? "R3 pull at delay" : "R2 pull at delay", {master_of(side), slave_of(side)}, 4'b0010);
      step(len - LAT_F);
      set_side(side, 1'b1);
      step(LAT_R - 1);
      check("R4 hold before release", {2'b0, slave_of(side)}, 4'b0010);
      step(1);
      check("R4 pulse start", {2'b0, slave_of(side)}, 4'b0001);
      step(PULSE - 1);
      check("R4 pulse last cycle", {2'b0, slave_of(side)}, 4'b0001);
      step(1);
      check("R4 passive after pulse", outs(), 4'b0000);
    end else begin
      bad = 1'b0;
      for (int i = 0; i < len; i++) begin
        step(1);
        if (slave_of(side) != 2'b00) bad = 1'b1;
      end
      set_side(side, 1'b1);
      for (int i = 0; i < LAT_F + PULSE + 5; i++) begin
        step(1);
        if (outs() != 4'b0000) bad = 1'b1;
      end
      check("R7 short low not forwarded", {3'b0, bad}, 4'b0000);
    end
    step(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic bad;
    step(3);
    check("R1 outputs in reset", outs(), 4'b0000);
    rst_n = 1'b1;
    step(5);
    check("R1 idle after reset", outs(), 4'b0000);

    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][17], int'(VEC[v][16:1]), VEC[v][0]);
    end

    // R5: card falls during host transfer (wait phase), held through
    host_ext = 1'b0;
    step(10);
    card_ext = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < LAT_F + 40; i++) begin
      step(1);
      if (host_pull_lo || host_drive_hi) bad = 1'b1;
    end
    check("R5 card pulled while host master", {3'b0, card_pull_lo}, 4'b0001);
    host_ext = 1'b1;
    step(LAT_R + PULSE + 2);
    card_ext = 1'b1;
    for (int i = 0; i < LAT_F + 10; i++) begin
      step(1);
      if (host_pull_lo || host_drive_hi) bad = 1'b1;
    end
    check("R5 slave edge locked out", {3'b0, bad}, 4'b0000);
    step(5);

    // R6: both fall together, host wins
    host_ext = 1'b0;
    card_ext = 1'b0;
    step(LAT_F);
    check("R6 host wins tie", outs(), 4'b0010);
    host_ext = 1'b1;
    card_ext = 1'b1;
    step(LAT_R);
    check("R6 pulse goes to card", outs(), 4'b0001);
    step(PULSE + 8);

    // R9: master falls again mid-pulse
    host_ext = 1'b0;
    step(LAT_F + 5);
    host_ext = 1'b1;
    step(LAT_R + PULSE / 2);
    check("R9 pulse running", outs(), 4'b0001);
    host_ext = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < LAT_F + PULSE + 10; i++) begin
      step(1);
      if (card_pull_lo || host_pull_lo) bad = 1'b1;
    end
    check("R9 edge during pulse ignored", {3'b0, bad}, 4'b0000);
    host_ext = 1'b1;
    step(10);

    // R8: disable during hold
    host_ext = 1'b0;
    step(LAT_F + 5);
    check("R8 hold before disable", outs(), 4'b0010);
    enable = 1'b0;
    #1;
    check("R8 disabled outputs", outs(), 4'b0010);
    step(5);
    host_ext = 1'b1;
    step(5);
    check("R8 disabled card parked low", outs(), 4'b0010);
    enable = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < LAT_F + PULSE + 5; i++) begin
      step(1);
      if (outs() != 4'b0000) bad = 1'b1;
    end
    check("R8 no pulse after re-enable", {3'b0, bad}, 4'b0000);

    // R3 again after everything, card master
    xfer(1'b1, 70, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule